// File: doc/BRIEF.md
# I/O Processor Interrupt Status Hub

This block collects the interrupt requests of an I/O processor's peripherals into a single status byte. The processor polls this byte over a small byte-wide port interface. The peripherals are a floppy controller, a keyboard, a printer with separate transmit-ready and receive-ready requests, a time-of-day tick, an RS-232 device, a serial UART with separate transmit and receive requests, and the attention line of a companion central processor. Every request input is asynchronous, so each one passes through a two-flop synchronizer before it is latched or shown.

Four bits of the status byte are active-high and three are active-low. The remaining bit reports a sticky time-of-day flag. A write to the port one address above the status byte clears that flag. A read of that same address returns an externally supplied keyboard data byte.

Three restart interrupt lines go to the CPU. The highest follows the floppy request and the middle follows the RS-232 request. The lowest is a sticky flag. It is set by a rising edge of the companion processor's attention line and cleared by an acknowledge write.

Top module: `irq_status_hub`

## Requirements
- R1: After reset, irq_hi, irq_mid and irq_lo are low and the time-of-day flag (status bit 3) reads 0.
- R2: Reading address STATUS_ADDR (default 0xE9) returns floppy in bit 7, keyboard in bit 6, printer transmit-ready in bit 5 and printer receive-ready in bit 4, all active-high. Each bit reflects its input two clock edges after the input changes.
- R3: In the same status byte, bit 2 is the inverse of the RS-232 request, bit 1 the inverse of the UART transmit request and bit 0 the inverse of the UART receive request.
- R4: A time-of-day tick held high for at least one cycle sets status bit 3 by the third edge. The bit stays set until a write to STATUS_ADDR+1, whatever the data.
- R5: If a tick sets the time-of-day flag on the same edge as a clear write, the flag stays set.
- R6: irq_hi follows the synchronized floppy request and irq_mid follows the synchronized RS-232 request, each two edges after the input changes.
- R7: A low-to-high transition of cp_attn sets irq_lo by the third edge after it. irq_lo then stays high whether cp_attn stays high or falls. A cp_attn that stays high does not set it again.
- R8: A write to STATUS_ADDR with data bit 0 equal to 1 clears irq_lo. The same write with data bit 0 equal to 0 leaves irq_lo unchanged.
- R9: Reading STATUS_ADDR+1 returns kbd_latch. Reading any other address, or not reading at all, yields 0x00.
- R10: A write to STATUS_ADDR does not alter the time-of-day flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 8 | Port address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_rdata | output | 8 | Read data, combinational |
| kbd_latch | input | 8 | Keyboard data byte shown at STATUS_ADDR+1 |
| fdc_req | input | 1 | Floppy request, async |
| kbd_req | input | 1 | Keyboard request, async |
| prn_tx_rdy | input | 1 | Printer transmit-ready, async |
| prn_rx_rdy | input | 1 | Printer receive-ready, async |
| tod_tick | input | 1 | Time-of-day tick, async |
| rs232_req | input | 1 | RS-232 request, async |
| uart_tx_req | input | 1 | UART transmit request, async |
| uart_rx_req | input | 1 | UART receive request, async |
| cp_attn | input | 1 | Companion processor attention, async |
| irq_hi | output | 1 | Highest-priority restart line |
| irq_mid | output | 1 | Middle restart line |
| irq_lo | output | 1 | Lowest-priority restart line |

## Verification
The assertions check four things on every cycle. The read bus is zero without a read strobe. Status bit 7 agrees with irq_hi and status bit 2 with the inverse of irq_mid. The keyboard byte appears at the clear port. irq_lo, once set, persists until an acknowledge write. The bench scenarios cover the rest: the full bit layout under varied request patterns, the synchronizer delays, edge-only setting of irq_lo, and the tie between a tick and a clear write.

// File: rtl/irq_hub_pkg.sv
// Shared definitions for the interrupt status hub: status bit positions
// and the bundle of raw request lines. Assumes an 8-bit status byte.
package irq_hub_pkg;
    localparam int BIT_FDC  = 7;
    localparam int BIT_KBD  = 6;
    localparam int BIT_PTX  = 5;
    localparam int BIT_PRX  = 4;
    localparam int BIT_TOD  = 3;
    localparam int BIT_RS   = 2;
    localparam int BIT_UTX  = 1;
    localparam int BIT_URX  = 0;

    typedef struct packed {
        logic fdc;
        logic kbd;
        logic ptx;
        logic prx;
        logic rs232;
        logic utx;
        logic urx;
        logic tick;
        logic attn;
    } req_bundle_t;
endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each input holds for at least one clock to be seen.
module irq_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[g] <= '0;
                else if (g == 0)
                    stg[g] <= d_async;
                else
                    stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/irq_sticky.sv
// Sticky flags: time-of-day pending (set by synchronized tick level) and
// attention pending (set by a rising edge of synchronized attention).
// Set has priority over clear on the same edge.
module irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_s,
    input  logic tod_clr,
    input  logic attn_s,
    input  logic attn_ack,
    output logic tod_pend,
    output logic attn_pend
);
    logic attn_prev;

    // Remember last attention level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) attn_prev <= 1'b0;
        else        attn_prev <= attn_s;
    end

    // Time-of-day latch: tick sets, clear-port write clears.
    always_ff @(posedge clk) begin
        if (!rst_n)       tod_pend <= 1'b0;
        else if (tick_s)  tod_pend <= 1'b1;
        else if (tod_clr) tod_pend <= 1'b0;
    end

    // Attention latch: rising edge sets, acknowledge write clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                     attn_pend <= 1'b0;
        else if (attn_s && !attn_prev)  attn_pend <= 1'b1;
        else if (attn_ack)              attn_pend <= 1'b0;
    end
endmodule

// File: rtl/irq_read_mux.sv
// Read-data selection: status byte at the status address, keyboard byte
// one address up, zero elsewhere or without a read strobe.
module irq_read_mux
    import irq_hub_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int          DW          = 8,
    parameter logic [7:0]  STATUS_ADDR = 8'hE9
) (
    input  req_bundle_t    req_s,
    input  logic           tod_pend,
    input  logic [AW-1:0]  io_addr,
    input  logic           io_rd,
    input  logic [DW-1:0]  kbd_latch,
    output logic [DW-1:0]  io_rdata
);
    localparam logic [AW-1:0] CLR_ADDR = AW'(STATUS_ADDR) + AW'(1);

    logic [DW-1:0] status;

    // Assemble the status byte with its mixed polarities.
    always_comb begin
        status          = '0;
        status[BIT_FDC] = req_s.fdc;
        status[BIT_KBD] = req_s.kbd;
        status[BIT_PTX] = req_s.ptx;
        status[BIT_PRX] = req_s.prx;
        status[BIT_TOD] = tod_pend;
        status[BIT_RS]  = ~req_s.rs232;
        status[BIT_UTX] = ~req_s.utx;
        status[BIT_URX] = ~req_s.urx;
    end

    // Choose the read data by address.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (io_addr == AW'(STATUS_ADDR)) io_rdata = status;
            else if (io_addr == CLR_ADDR)    io_rdata = kbd_latch;
        end
    end
endmodule

// File: rtl/irq_status_hub.sv
// Interrupt status hub top: synchronizes request inputs, keeps sticky
// time-of-day and attention flags, presents the status byte and drives
// three restart interrupt lines. Assumes a synchronous active-low reset.
module irq_status_hub
    import irq_hub_pkg::*;
#(
    parameter int         AW          = 8,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] STATUS_ADDR = 8'hE9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] io_addr,
    input  logic [DW-1:0] io_wdata,
    input  logic          io_rd,
    input  logic          io_wr,
    output logic [DW-1:0] io_rdata,
    input  logic [DW-1:0] kbd_latch,
    input  logic          fdc_req,
    input  logic          kbd_req,
    input  logic          prn_tx_rdy,
    input  logic          prn_rx_rdy,
    input  logic          tod_tick,
    input  logic          rs232_req,
    input  logic          uart_tx_req,
    input  logic          uart_rx_req,
    input  logic          cp_attn,
    output logic          irq_hi,
    output logic          irq_mid,
    output logic          irq_lo
);
    localparam int              RW       = $bits(req_bundle_t);
    localparam logic [AW-1:0]   CLR_ADDR = AW'(STATUS_ADDR) + AW'(1);

    req_bundle_t req_raw, req_s;
    logic [RW-1:0] req_s_vec;
    logic tod_clr, attn_ack, tod_pend, attn_pend;

    // Bundle the raw request lines.
    always_comb begin
        req_raw.fdc   = fdc_req;
        req_raw.kbd   = kbd_req;
        req_raw.ptx   = prn_tx_rdy;
        req_raw.prx   = prn_rx_rdy;
        req_raw.rs232 = rs232_req;
        req_raw.utx   = uart_tx_req;
        req_raw.urx   = uart_rx_req;
        req_raw.tick  = tod_tick;
        req_raw.attn  = cp_attn;
    end

    irq_sync #(.WIDTH(RW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_raw),
        .q_sync  (req_s_vec)
    );
    assign req_s = req_bundle_t'(req_s_vec);

    // Decode the two write actions.
    always_comb begin
        tod_clr  = io_wr && (io_addr == CLR_ADDR);
        attn_ack = io_wr && (io_addr == AW'(STATUS_ADDR)) && io_wdata[0];
    end

    irq_sticky u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_s    (req_s.tick),
        .tod_clr   (tod_clr),
        .attn_s    (req_s.attn),
        .attn_ack  (attn_ack),
        .tod_pend  (tod_pend),
        .attn_pend (attn_pend)
    );

    irq_read_mux #(.AW(AW), .DW(DW), .STATUS_ADDR(STATUS_ADDR)) u_mux (
        .req_s     (req_s),
        .tod_pend  (tod_pend),
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .kbd_latch (kbd_latch),
        .io_rdata  (io_rdata)
    );

    // Drive the three restart lines by priority rank.
    always_comb begin
        irq_hi  = req_s.fdc;
        irq_mid = req_s.rs232;
        irq_lo  = attn_pend;
    end
endmodule

// File: rtl/irq_status_hub_chk.sv
// Port-level checker for irq_status_hub, attached with bind.
module irq_status_hub_chk #(
    parameter logic [7:0] STATUS_ADDR = 8'hE9
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] io_addr,
    input logic [7:0] io_wdata,
    input logic       io_rd,
    input logic       io_wr,
    input logic [7:0] io_rdata,
    input logic [7:0] kbd_latch,
    input logic       irq_hi,
    input logic       irq_mid,
    input logic       irq_lo
);
    // R9
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == 8'h00);
    // R9
    kbd_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == STATUS_ADDR + 8'd1) |-> io_rdata == kbd_latch);
    // R6
    fdc_bit_matches_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == STATUS_ADDR) |-> io_rdata[7] == irq_hi);
    // R3
    rs_bit_inverts_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == STATUS_ADDR) |-> io_rdata[2] == !irq_mid);
    // R8
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && !(io_wr && io_addr == STATUS_ADDR && io_wdata[0])) |=> irq_lo);
endmodule

bind irq_status_hub irq_status_hub_chk #(.STATUS_ADDR(STATUS_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_rdata  (io_rdata),
    .kbd_latch (kbd_latch),
    .irq_hi    (irq_hi),
    .irq_mid   (irq_mid),
    .irq_lo    (irq_lo)
);

// File: tb/irq_status_hub_test.sv
module irq_status_hub_test;
    localparam logic [7:0] SA = 8'hE9;

    logic clk = 0, rst_n = 0;
    logic [7:0] io_addr = 0, io_wdata = 0, kbd_latch = 8'h5C;
    logic io_rd = 0, io_wr = 0;
    logic [7:0] io_rdata;
    logic fdc_req = 0, kbd_req = 0, prn_tx_rdy = 0, prn_rx_rdy = 0, tod_tick = 0;
    logic rs232_req = 0, uart_tx_req = 0, uart_rx_req = 0, cp_attn = 0;
    logic irq_hi, irq_mid, irq_lo;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_status_hub uut (.*);

    // {fdc,kbd,ptx,prx,rs,utx,urx} , expected status byte
    localparam logic [14:0] VEC [10] = '{
        {7'b0000000, 8'h07}, {7'b1000000, 8'h87}, {7'b0100000, 8'h47},
        {7'b0010000, 8'h27}, {7'b0001000, 8'h17}, {7'b0000100, 8'h03},
        {7'b0000010, 8'h05}, {7'b0000001, 8'h06}, {7'b1111111, 8'hF0},
        {7'b1010101, 8'hA2}};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1; #0.5; d = io_rdata; io_rd = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(posedge clk); @(negedge clk);
        io_wr = 0; io_wdata = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        cycles(3);
        rst_n = 1;
        cycles(1);
        // R1 reset state
        check("R1 irq lines", {5'b0, irq_hi, irq_mid, irq_lo}, 8'h00);
        rd(SA, d); check("R1 tod bit", {7'b0, d[3]}, 8'h00);

        // R2 R3 vector table
        for (int i = 0; i < 10; i++) begin
            {fdc_req, kbd_req, prn_tx_rdy, prn_rx_rdy, rs232_req, uart_tx_req, uart_rx_req} = VEC[i][14:8];
            cycles(3);
            rd(SA, d); check("R2 R3 status layout", d, VEC[i][7:0]);
            check("R6 irq hi/mid", {6'b0, irq_hi, irq_mid}, {6'b0, VEC[i][14], VEC[i][10]});
        end

        // R2 R6 two-edge latency
        {fdc_req, kbd_req, prn_tx_rdy, prn_rx_rdy, rs232_req, uart_tx_req, uart_rx_req} = 0;
        cycles(3);
        fdc_req = 1; rs232_req = 1;
        cycles(1);
        check("R6 not yet after one edge", {6'b0, irq_hi, irq_mid}, 8'h00);
        cycles(1);
        check("R6 after two edges", {6'b0, irq_hi, irq_mid}, 8'h03);
        rd(SA, d); check("R2 floppy bit after two edges", d, 8'h83);
        fdc_req = 0; rs232_req = 0; cycles(3);

        // R9 keyboard byte and other addresses
        rd(SA + 8'd1, d); check("R9 keyboard latch", d, 8'h5C);
        kbd_latch = 8'hA7; rd(SA + 8'd1, d); check("R9 keyboard latch 2", d, 8'hA7);
        rd(8'h10, d); check("R9 other address", d, 8'h00);
        io_addr = SA; #0.5; check("R9 no strobe", io_rdata, 8'h00);

        // R4 tod set and clear
        tod_tick = 1; cycles(1); tod_tick = 0;
        cycles(3);
        rd(SA, d); check("R4 tod set", {7'b0, d[3]}, 8'h01);
        cycles(4);
        rd(SA, d); check("R4 tod holds", {7'b0, d[3]}, 8'h01);
        // R10 write to status address leaves tod
        wr(SA, 8'hFE);
        rd(SA, d); check("R10 tod after status write", {7'b0, d[3]}, 8'h01);
        wr(SA + 8'd1, 8'h00);
        rd(SA, d); check("R4 tod cleared", {7'b0, d[3]}, 8'h00);

        // R5 set wins over clear on same edge
        tod_tick = 1; cycles(1); tod_tick = 0;
        cycles(1);
        wr(SA + 8'd1, 8'hFF);
        rd(SA, d); check("R5 set beats clear", {7'b0, d[3]}, 8'h01);
        wr(SA + 8'd1, 8'hFF);
        rd(SA, d); check("R5 later clear", {7'b0, d[3]}, 8'h00);

        // R7 attention edge
        cp_attn = 1;
        cycles(2);
        check("R7 not before third edge", {7'b0, irq_lo}, 8'h00);
        cycles(1);
        check("R7 set on rise", {7'b0, irq_lo}, 8'h01);
        // R8 ack with bit0=0 no effect
        wr(SA, 8'h02);
        check("R8 ack bit0 clear ignored", {7'b0, irq_lo}, 8'h01);
        wr(SA, 8'h01);
        check("R8 ack clears", {7'b0, irq_lo}, 8'h00);
        cycles(5);
        check("R7 steady high no reset", {7'b0, irq_lo}, 8'h00);
        cp_attn = 0; cycles(3);
        cp_attn = 1; cycles(3);
        check("R7 second rise", {7'b0, irq_lo}, 8'h01);
        cp_attn = 0; cycles(4);
        check("R7 holds after fall", {7'b0, irq_lo}, 8'h01);

        // R1 reset mid-run clears everything
        tod_tick = 1; cycles(1); tod_tick = 0; cycles(3);
        rst_n = 0; cycles(1); rst_n = 1;
        check("R1 reset clears irq_lo", {7'b0, irq_lo}, 8'h00);
        rd(SA, d); check("R1 reset clears tod", {7'b0, d[3]}, 8'h00);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule